// File: doc/BRIEF.md
# Time-Multiplexed Tower Input Scheduler

This block sits in front of a small bank of parallel algorithm cores. Those cores must together produce one result for every core tower in each bunch crossing. The fast clock runs at five times the crossing rate. A load strobe, high for a single fast cycle, marks the start of each crossing. On that strobe the block captures a 60-tower input word. The word holds 40 core towers arranged as 4 eta columns of 10 phi rows, and 20 environment towers arranged as one eta column on each side. Over the next five fast cycles the block hands 8 core towers per cycle to its 8 core ports. Each port carries the centre tower, its west and east eta neighbours, the core tower index and a valid bit.

A two-bit position input tells the block whether the module sits on the eta border of the detector, and if so on which side. On a border module the outer environment column has no real data behind it. That column is replaced by zeros when the word is captured, so every core that reaches across the border sees dummy zero data.

Sequencing is done by a two-state machine with a phase counter. ST_IDLE means no crossing is being served and the counter is parked on the last phase. ST_RUN means phases 0 to 4 are being presented. The transitions are named as follows:
- T_LOAD: any state moves to ST_RUN at phase 0 on a strobe.
- T_STEP: ST_RUN advances one phase.
- T_EXPIRE: ST_RUN at phase 4 with no strobe moves to ST_IDLE.
- T_WAIT: ST_IDLE with no strobe stays in ST_IDLE.

Top module: `tsched_top`

## Requirements
- R1: After reset no core port is valid, the phase output reads 4, and every index and data output is zero.
- R2: A load strobe sampled at a clock edge captures the input word and the position flags. The phase output reads 0 and all core ports are valid in the cycle right after that edge.
- R3: Without a new strobe, the phase advances by exactly one per cycle from 0 to 4, never exceeds 4, and the ports stay valid for all five phases.
- R4: In phase p, core port c presents core tower index k = 8p + c on its index output. Core tower k lies in eta column k/10 + 1 and phase row k mod 10, and the tower at column col, row r occupies input bits [(10·col + r)·8 +: 8]. The centre output carries that tower.
- R5: The west and east outputs of a core port carry the towers in eta columns col − 1 and col + 1 of the same row.
- R6: Position bit 0 = 1 marks a border module and bit 1 = 1 selects the left side. Code 2'b11 zeroes column 0 and code 2'b01 zeroes column 5. With bit 0 clear, no tower is altered.
- R7: If no strobe arrives in phase 4, the next cycle drops valid on every port and holds the phase at 4. All index and data outputs read zero until the next strobe.
- R8: Changes of the input word or the position flags without a strobe have no effect on any output.
- R9: A strobe in the middle of a crossing restarts at phase 0 with the newly captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, five times the crossing rate |
| rst_n_i | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Crossing start strobe, one cycle wide |
| towers_i | input | 480 | 60 towers of 8 bits, tower t at bits [8t +: 8] |
| pos_i | input | 2 | Bit 0 border module, bit 1 left side |
| phase_o | output | 3 | Current phase 0..4 |
| valid_o | output | 8 | Per-port valid |
| idx_o | output | 48 | Per-port core tower index, 6 bits each |
| ctr_o | output | 64 | Per-port centre tower data |
| west_o | output | 64 | Per-port west neighbour data |
| east_o | output | 64 | Per-port east neighbour data |

## Verification
The assertions check the phase sequencing on every cycle:
- the restart to phase 0 after a strobe;
- the single-step advance and the upper bound on the phase;
- the drop to idle after phase 4;
- the stability of the captured word between strobes;
- the zeroing of the selected border column at capture.

Only the bench scenarios can show that each port routes the right tower and neighbours for each phase. The bench sweeps every phase, core and position code over several data patterns. It also checks the absence of effect of mid-crossing input changes and the contents after a mid-crossing restart.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_state_t;

endpackage

// File: rtl/tsched_phase_fsm.sv
module tsched_phase_fsm
    import tsched_pkg::*;
#(
    parameter int N_PHASES = 5,
    parameter int PW       = $clog2(N_PHASES)
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          load_i,
    output logic [PW-1:0] phase_o,
    output logic          active_o
);

    localparam logic [PW-1:0] LAST = PW'(N_PHASES - 1);

    sched_state_t  state_q, state_d;
    logic [PW-1:0] phase_q, phase_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= ST_IDLE;
            phase_q <= LAST;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // next state: T_LOAD, T_STEP, T_EXPIRE, T_WAIT
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        if (load_i) begin
            state_d = ST_RUN;
            phase_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                    phase_d = LAST;
                end
                ST_RUN: begin
                    if (phase_q == LAST) begin
                        state_d = ST_IDLE;
                        phase_d = LAST;
                    end else begin
                        state_d = ST_RUN;
                        phase_d = phase_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    phase_d = LAST;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        phase_o  = phase_q;
        active_o = (state_q == ST_RUN);
    end

    assert_load_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_i |=> (phase_q == '0 && state_q == ST_RUN));

    assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!load_i && state_q == ST_RUN && phase_q != LAST)
            |=> (state_q == ST_RUN && phase_q == PW'($past(phase_q) + 1'b1)));

    assert_phase_range_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        phase_q <= LAST);

    assert_expire_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!load_i && phase_q == LAST) |=> (state_q == ST_IDLE && phase_q == LAST));

endmodule

// File: rtl/tsched_capture.sv
module tsched_capture #(
    parameter int TW     = 8,
    parameter int N_ROWS = 10,
    parameter int N_COLS = 6,
    localparam int COLW  = N_ROWS * TW,
    localparam int WW    = N_COLS * COLW
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          load_i,
    input  logic [WW-1:0] towers_i,
    input  logic [1:0]    pos_i,
    output logic [WW-1:0] towers_o
);

    logic [WW-1:0] masked;
    logic [WW-1:0] store_q;

    // border substitution: bit 0 border, bit 1 left side
    always_comb begin
        masked = towers_i;
        if (pos_i[0]) begin
            if (pos_i[1]) begin
                masked[0 +: COLW] = '0;
            end else begin
                masked[(N_COLS-1)*COLW +: COLW] = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            store_q <= '0;
        end else if (load_i) begin
            store_q <= masked;
        end
    end

    assign towers_o = store_q;

    assert_hold_between_loads_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !load_i |=> $stable(towers_o));

    assert_left_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_i && pos_i == 2'b11) |=> (towers_o[0 +: COLW] == '0));

    assert_right_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_i && pos_i == 2'b01) |=> (towers_o[(N_COLS-1)*COLW +: COLW] == '0));

endmodule

// File: rtl/tsched_core_port.sv
module tsched_core_port #(
    parameter int TW       = 8,
    parameter int N_ROWS   = 10,
    parameter int N_CORES  = 8,
    parameter int CORE_ID  = 0,
    parameter int PW       = 3,
    parameter int IW       = 6,
    parameter int N_TOWERS = 60
) (
    input  logic [PW-1:0]          phase_i,
    input  logic                   active_i,
    input  logic [N_TOWERS*TW-1:0] towers_i,
    output logic                   valid_o,
    output logic [IW-1:0]          idx_o,
    output logic [TW-1:0]          ctr_o,
    output logic [TW-1:0]          west_o,
    output logic [TW-1:0]          east_o
);

    int k;
    int col;
    int row;

    always_comb begin
        k   = int'(phase_i) * N_CORES + CORE_ID;
        col = k / N_ROWS + 1;
        row = k % N_ROWS;
        valid_o = 1'b0;
        idx_o   = '0;
        ctr_o   = '0;
        west_o  = '0;
        east_o  = '0;
        if (active_i) begin
            valid_o = 1'b1;
            idx_o   = IW'(k);
            ctr_o   = towers_i[(col * N_ROWS + row) * TW +: TW];
            west_o  = towers_i[((col - 1) * N_ROWS + row) * TW +: TW];
            east_o  = towers_i[((col + 1) * N_ROWS + row) * TW +: TW];
        end
    end

endmodule

// File: rtl/tsched_top.sv
module tsched_top #(
    parameter int TW          = 8,
    parameter int N_CORES     = 8,
    parameter int N_PHASES    = 5,
    parameter int N_ROWS      = 10,
    parameter int N_CORE_COLS = 4,
    localparam int N_COLS     = N_CORE_COLS + 2,
    localparam int N_TOWERS   = N_COLS * N_ROWS,
    localparam int N_CORE_TW  = N_CORE_COLS * N_ROWS,
    localparam int PW         = $clog2(N_PHASES),
    localparam int IW         = $clog2(N_CORE_TW)
) (
    input  logic                   clk_i,
    input  logic                   rst_n_i,
    input  logic                   load_i,
    input  logic [N_TOWERS*TW-1:0] towers_i,
    input  logic [1:0]             pos_i,
    output logic [PW-1:0]          phase_o,
    output logic [N_CORES-1:0]     valid_o,
    output logic [N_CORES*IW-1:0]  idx_o,
    output logic [N_CORES*TW-1:0]  ctr_o,
    output logic [N_CORES*TW-1:0]  west_o,
    output logic [N_CORES*TW-1:0]  east_o
);

    logic [PW-1:0]          phase;
    logic                   active;
    logic [N_TOWERS*TW-1:0] held;

    tsched_phase_fsm #(
        .N_PHASES (N_PHASES),
        .PW       (PW)
    ) i_fsm (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .load_i   (load_i),
        .phase_o  (phase),
        .active_o (active)
    );

    tsched_capture #(
        .TW     (TW),
        .N_ROWS (N_ROWS),
        .N_COLS (N_COLS)
    ) i_capture (
        .clk_i    (clk_i),
        .rst_n_i  (rst_n_i),
        .load_i   (load_i),
        .towers_i (towers_i),
        .pos_i    (pos_i),
        .towers_o (held)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        tsched_core_port #(
            .TW       (TW),
            .N_ROWS   (N_ROWS),
            .N_CORES  (N_CORES),
            .CORE_ID  (c),
            .PW       (PW),
            .IW       (IW),
            .N_TOWERS (N_TOWERS)
        ) i_port (
            .phase_i  (phase),
            .active_i (active),
            .towers_i (held),
            .valid_o  (valid_o[c]),
            .idx_o    (idx_o[c*IW +: IW]),
            .ctr_o    (ctr_o[c*TW +: TW]),
            .west_o   (west_o[c*TW +: TW]),
            .east_o   (east_o[c*TW +: TW])
        );
    end

    assign phase_o = phase;

endmodule

// File: tb/test_tsched_top.sv
module test_tsched_top;

    localparam int TW = 8;
    localparam int NC = 8;
    localparam int NR = 10;
    localparam int NT = 60;
    localparam int IW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            load = 1'b0;
    logic [NT*TW-1:0] towers = '0;
    logic [1:0]      pos = 2'b00;
    logic [2:0]      phase;
    logic [NC-1:0]   valid;
    logic [NC*IW-1:0] idx;
    logic [NC*TW-1:0] ctr, west, east;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tsched_top i_tsched_top (
        .clk_i    (clk),
        .rst_n_i  (rst_n),
        .load_i   (load),
        .towers_i (towers),
        .pos_i    (pos),
        .phase_o  (phase),
        .valid_o  (valid),
        .idx_o    (idx),
        .ctr_o    (ctr),
        .west_o   (west),
        .east_o   (east)
    );

    function automatic logic [7:0] raw(int pat, int t);
        return 8'(t * 7 + pat * 29 + 3) | 8'h01;
    endfunction

    function automatic logic [7:0] seen(int pat, int t, logic [1:0] p);
        int col;
        col = t / NR;
        if (p == 2'b11 && col == 0) return 8'h00;
        if (p == 2'b01 && col == 5) return 8'h00;
        return raw(pat, t);
    endfunction

    task automatic fill(int pat);
        for (int t = 0; t < NT; t++) towers[t*TW +: TW] = raw(pat, t);
    endtask

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // all ports idle: R1 / R7
    task automatic chk_idle(string req);
        chk(req, "phase", int'(phase), 4);
        chk(req, "valid", int'(valid), 0);
        chk(req, "idx", int'(|idx), 0);
        chk(req, "data", int'(|{ctr, west, east}), 0);
    endtask

    // phase p of a crossing with pattern pat and position p2
    task automatic chk_phase(int p, int pat, logic [1:0] p2);
        chk("R3", "phase", int'(phase), p);
        for (int c = 0; c < NC; c++) begin
            int k, col, row;
            k = p * NC + c;
            col = k / NR + 1;
            row = k % NR;
            chk("R3", "valid", int'(valid[c]), 1);
            chk("R4", "idx", int'(idx[c*IW +: IW]), k);
            chk("R4", "ctr", int'(ctr[c*TW +: TW]), int'(seen(pat, col*NR + row, p2)));
            chk("R5", "west", int'(west[c*TW +: TW]), int'(seen(pat, (col-1)*NR + row, p2)));
            chk("R5", "east", int'(east[c*TW +: TW]), int'(seen(pat, (col+1)*NR + row, p2)));
        end
    endtask

    // called at a negedge; returns at the negedge where phase 4 is shown
    task automatic crossing(int pat, logic [1:0] p2, bit scramble);
        fill(pat);
        pos = p2;
        load = 1'b1;
        for (int p = 0; p < 5; p++) begin
            @(negedge clk);
            load = 1'b0;
            if (p == 1 && scramble) begin
                fill(pat + 5);   // R8: no strobe, must be ignored
                pos = ~p2;
            end
            chk_phase(p, pat, p2);
        end
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] modes [3];
        modes[0] = 2'b00;
        modes[1] = 2'b11;
        modes[2] = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1");
        // back-to-back crossings, every mode and several patterns (R2..R6)
        for (int m = 0; m < 3; m++) begin
            for (int pat = 0; pat < 4; pat++) begin
                crossing(pat + m * 4, modes[m], 1'b0);
            end
        end
        // R7: no strobe after phase 4
        @(negedge clk);
        chk_idle("R7");
        @(negedge clk);
        chk_idle("R7");
        // R8: mid-crossing changes without a strobe
        crossing(20, 2'b11, 1'b1);
        @(negedge clk);
        fill(31);
        pos = 2'b00;
        @(negedge clk);
        chk_idle("R8");
        // R9: restart mid-crossing with new data
        fill(40);
        pos = 2'b01;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk_phase(0, 40, 2'b01);
        @(negedge clk);
        chk_phase(1, 40, 2'b01);
        @(negedge clk);
        chk("R9", "phase before restart", int'(phase), 2);
        crossing(41, 2'b11, 1'b0);
        chk("R9", "phase after restart", int'(phase), 4);
        @(negedge clk);
        chk_idle("R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule